// File: doc/BRIEF.md
# Bridge Control and Status Register with Interrupt Output

This block is the single 64-bit control and status word of a system-bus-to-PCI bridge. Software reaches it through a plain one-cycle write strobe with a full-width data word; the current contents are always visible on a read bus. The word holds four kinds of field: the delayed-read latency count, a set of sticky event flags, a doorbell set/status pair and the mode and enable bits.

Event pulses from the rest of the bridge set the sticky flags. Software clears a flag by writing 1 to its bit. The block combines the flags with the enable bits into one registered interrupt line. It also drives the latency count and the mode and enable bits out to the bridge logic. Every write loads the whole word: the latency count and the enable bits take the written value, and the flag bits act as clear requests. There is no streaming data path, so all pins are plain control and status signals with no valid/ready handshake.

Top module: `brg_csr`

## Requirements
- R1: After reset the read word is 64'h0000_0000_0030_0019: the latency count is 8'h30, bits 4, 3 and 0 are 1, and every other bit is 0. The irq output is 0.
- R2: Bits 63:24, 15, 12 and 7:5 always read 0, and a write cannot change them.
- R3: A write loads bits 23:16 into the latency count. The count reads back on those bits and appears on lat_timer after the clock edge that takes the write.
- R4: A pulse on ev_pci_rst, ev_orphan, ev_pci_err, ev_win_err or ev_bus_err sets bit 14, 13, 10, 9 or 8 respectively. The bit stays set after the pulse ends.
- R5: Writing 1 to bit 14, 13, 11, 10, 9 or 8 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R6: When an event or doorbell set reaches a flag in the same cycle as a write-1 clear of that flag, the flag ends set.
- R7: Writing 1 to bit 12 (doorbell set) sets bit 11 (doorbell status). Bit 12 itself reads 0.
- R8: One cycle after the register state changes, irq equals bit0 AND ((bit13 AND bit4) OR bit11 OR bit10 OR bit9 OR bit8). Bit 14 never raises irq.
- R9: When bit 0 is 0, irq stays 0, whatever bit 4 and the flags hold.
- R10: Bits 4..0 (orphan interrupt enable, arbiter enable, host mode, bridge enable, global interrupt enable) are read/write. Bits 3, 2 and 1 drive arb_en, host_mode and bridge_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 64 | Write data word |
| ev_pci_rst | input | 1 | Incoming PCI reset seen (pulse) |
| ev_orphan | input | 1 | Delayed read left unclaimed (pulse) |
| ev_pci_err | input | 1 | PCI parity or fatal error (pulse) |
| ev_win_err | input | 1 | Access crossed a window boundary (pulse) |
| ev_bus_err | input | 1 | System bus error reported (pulse) |
| rd_data | output | 64 | Current register contents |
| irq | output | 1 | Registered interrupt request |
| lat_timer | output | 8 | Delayed-read latency count |
| host_mode | output | 1 | 1 for host operation, 0 for satellite |
| arb_en | output | 1 | Arbiter enable |
| bridge_en | output | 1 | Bridge enable (PCI command bit 2) |

## Verification
A hardware event and a software clear can reach the same sticky flag in the same clock cycle. A doorbell set and a doorbell-status clear can also arrive in one write. The bench provokes both by driving an event pulse and a write-1 word on the same falling edge, and by writing a word with bits 12 and 11 both set. It then reads the word one edge later and expects the flag to be set. A sweep over every event combination under each pairing of the two interrupt enables checks the flag readback, and checks irq one further cycle later against a value computed from the enable equation.

// File: rtl/brg_csr_pkg.sv
package brg_csr_pkg;
  localparam int unsigned CSR_W   = 64;
  localparam int unsigned NUM_EV  = 5;
  localparam int unsigned NUM_FLG = NUM_EV + 1;   // events plus doorbell status

  // bit positions that software decodes
  localparam int unsigned B_PCIRST = 14;
  localparam int unsigned B_ORPHAN = 13;
  localparam int unsigned B_BELSET = 12;
  localparam int unsigned B_BELSTS = 11;
  localparam int unsigned B_PCIERR = 10;
  localparam int unsigned B_WINERR = 9;
  localparam int unsigned B_BUSERR = 8;
  localparam int unsigned B_ORPEN  = 4;
  localparam int unsigned B_ARBEN  = 3;
  localparam int unsigned B_HOST   = 2;
  localparam int unsigned B_BRGEN  = 1;
  localparam int unsigned B_INTEN  = 0;
  localparam int unsigned LT_LSB   = 16;

  // flag cell index -> register bit
  localparam int unsigned FLAG_POS [NUM_FLG] =
    '{B_PCIRST, B_ORPHAN, B_PCIERR, B_WINERR, B_BUSERR, B_BELSTS};

  localparam int unsigned F_PCIRST = 0;
  localparam int unsigned F_ORPHAN = 1;
  localparam int unsigned F_PCIERR = 2;
  localparam int unsigned F_WINERR = 3;
  localparam int unsigned F_BUSERR = 4;
  localparam int unsigned F_BELL   = 5;

  typedef struct packed {
    logic orp_en;
    logic arb_en;
    logic host;
    logic brg_en;
    logic int_en;
  } ctl_bits_t;

  localparam ctl_bits_t CTL_RST = '{orp_en: 1'b1, arb_en: 1'b1, host: 1'b0,
                                    brg_en: 1'b0, int_en: 1'b1};
endpackage

// File: rtl/brg_sticky_cell.sv
module brg_sticky_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority so that no event is lost to a concurrent clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/brg_ctl_fields.sv
module brg_ctl_fields
  import brg_csr_pkg::*;
#(
  parameter int unsigned LT_W           = 8,
  parameter logic [LT_W-1:0] LT_RST_VAL = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [LT_W-1:0] lt_wdata,
  input  ctl_bits_t       ctl_wdata,
  output logic [LT_W-1:0] lt_q,
  output ctl_bits_t       ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lt_q  <= LT_RST_VAL;
      ctl_q <= CTL_RST;
    end else if (wr_en) begin
      lt_q  <= lt_wdata;
      ctl_q <= ctl_wdata;
    end
  end
endmodule

// File: rtl/brg_irq_gen.sv
module brg_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic int_en,
  input  logic orp_en,
  input  logic orphan,
  input  logic bell,
  input  logic pci_err,
  input  logic win_err,
  input  logic bus_err,
  output logic irq_q
);
  logic orp_req;
  logic any_req;

  // orphan request needs both its own enable and the global enable
  assign orp_req = orphan & orp_en;
  assign any_req = orp_req | bell | pci_err | win_err | bus_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= int_en & any_req;
  end
endmodule

// File: rtl/brg_csr.sv
module brg_csr
  import brg_csr_pkg::*;
#(
  parameter int unsigned LT_W           = 8,
  parameter logic [LT_W-1:0] LT_RST_VAL = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             ev_pci_rst,
  input  logic             ev_orphan,
  input  logic             ev_pci_err,
  input  logic             ev_win_err,
  input  logic             ev_bus_err,
  output logic [CSR_W-1:0] rd_data,
  output logic             irq,
  output logic [LT_W-1:0]  lat_timer,
  output logic             host_mode,
  output logic             arb_en,
  output logic             bridge_en
);
  localparam int unsigned LT_MSB = LT_LSB + LT_W - 1;

  logic [NUM_FLG-1:0] flg_set;
  logic [NUM_FLG-1:0] flg_clr;
  logic [NUM_FLG-1:0] flg_q;
  ctl_bits_t          ctl_wr;
  ctl_bits_t          ctl_q;
  logic [LT_W-1:0]    lt_q;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[CSR_W-1:LT_MSB+1], wr_data[15], wr_data[7:5]};

  // set sources: hardware events, plus the doorbell write
  assign flg_set[F_PCIRST] = ev_pci_rst;
  assign flg_set[F_ORPHAN] = ev_orphan;
  assign flg_set[F_PCIERR] = ev_pci_err;
  assign flg_set[F_WINERR] = ev_win_err;
  assign flg_set[F_BUSERR] = ev_bus_err;
  assign flg_set[F_BELL]   = wr_en & wr_data[B_BELSET];

  generate
    for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
      assign flg_clr[i] = wr_en & wr_data[FLAG_POS[i]];
      brg_sticky_cell #(.RST_VAL(1'b0)) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (flg_set[i]),
        .clr_i (flg_clr[i]),
        .q_o   (flg_q[i])
      );
    end
  endgenerate

  assign ctl_wr.orp_en = wr_data[B_ORPEN];
  assign ctl_wr.arb_en = wr_data[B_ARBEN];
  assign ctl_wr.host   = wr_data[B_HOST];
  assign ctl_wr.brg_en = wr_data[B_BRGEN];
  assign ctl_wr.int_en = wr_data[B_INTEN];

  brg_ctl_fields #(.LT_W(LT_W), .LT_RST_VAL(LT_RST_VAL)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .lt_wdata  (wr_data[LT_MSB:LT_LSB]),
    .ctl_wdata (ctl_wr),
    .lt_q      (lt_q),
    .ctl_q     (ctl_q)
  );

  brg_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .int_en  (ctl_q.int_en),
    .orp_en  (ctl_q.orp_en),
    .orphan  (flg_q[F_ORPHAN]),
    .bell    (flg_q[F_BELL]),
    .pci_err (flg_q[F_PCIERR]),
    .win_err (flg_q[F_WINERR]),
    .bus_err (flg_q[F_BUSERR]),
    .irq_q   (irq)
  );

  always_comb begin
    rd_data = '0;
    rd_data[LT_MSB:LT_LSB] = lt_q;
    for (int i = 0; i < NUM_FLG; i++) rd_data[FLAG_POS[i]] = flg_q[i];
    rd_data[B_ORPEN] = ctl_q.orp_en;
    rd_data[B_ARBEN] = ctl_q.arb_en;
    rd_data[B_HOST]  = ctl_q.host;
    rd_data[B_BRGEN] = ctl_q.brg_en;
    rd_data[B_INTEN] = ctl_q.int_en;
  end

  assign lat_timer = lt_q;
  assign host_mode = ctl_q.host;
  assign arb_en    = ctl_q.arb_en;
  assign bridge_en = ctl_q.brg_en;
endmodule

// File: rtl/brg_csr_chk.sv
module brg_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [63:0] wr_data,
  input logic        ev_orphan,
  input logic        ev_win_err,
  input logic [63:0] rd_data,
  input logic        irq
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[63:24] == '0) && !rd_data[15] && !rd_data[12] && (rd_data[7:5] == '0));

  assert_lat_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[23:16] == $past(wr_data[23:16]));

  assert_event_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_orphan |=> rd_data[13]);

  assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] && !(wr_en && wr_data[9])) |=> rd_data[9]);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_win_err && wr_en && wr_data[9]) |=> rd_data[9]);

  assert_bell_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12]) |=> rd_data[11]);

  assert_irq_eq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(rd_data[0] & ((rd_data[13] & rd_data[4]) | (|rd_data[11:8]))));

  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[0] |=> !irq);
endmodule

bind brg_csr brg_csr_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .ev_orphan  (ev_orphan),
  .ev_win_err (ev_win_err),
  .rd_data    (rd_data),
  .irq        (irq)
);

// File: tb/brg_csr_tb.sv
module brg_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [4:0]  ev = '0;
  logic [63:0] rd_data;
  logic        irq;
  logic [7:0]  lat_timer;
  logic        host_mode, arb_en, bridge_en;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  brg_csr u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ev_pci_rst(ev[0]), .ev_orphan(ev[1]), .ev_pci_err(ev[2]),
    .ev_win_err(ev[3]), .ev_bus_err(ev[4]),
    .rd_data(rd_data), .irq(irq), .lat_timer(lat_timer),
    .host_mode(host_mode), .arb_en(arb_en), .bridge_en(bridge_en)
  );

  localparam logic [63:0] CLR_ALL = 64'h6F00;  // flag bits 14,13,11,10,9,8

  function automatic logic [63:0] ctl(input logic [7:0] lt, input logic [4:0] en);
    return {40'h0, lt, 11'h0, en};
  endfunction

  // event index -> register bit
  function automatic logic [63:0] ev_bits(input logic [4:0] e);
    logic [63:0] r = '0;
    r[14] = e[0]; r[13] = e[1]; r[10] = e[2]; r[9] = e[3]; r[8] = e[4];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [4:0] e);
    @(negedge clk); ev = e;
    @(negedge clk); ev = '0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset word", rd_data, 64'h0030_0019);
    chk("R1 reset irq", {63'h0, irq}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: all-ones write; bell set forces bell status, reserved bits stay 0
    wr('1);
    chk("R2 all ones readback", rd_data, 64'h00FF_081F);
    wr(ctl(8'h30, 5'h19) | CLR_ALL);
    chk("R5 clear all", rd_data, 64'h0030_0019);

    // R3: exhaustive latency sweep
    for (int v = 0; v < 256; v++) begin
      wr(ctl(v[7:0], 5'h19));
      chk("R3 latency readback", rd_data[23:16], v);
      chk("R3 latency port", lat_timer, v);
    end

    // R10: every enable combination, readback and exported pins
    for (int e = 0; e < 32; e++) begin
      wr(ctl(8'h30, e[4:0]));
      chk("R10 enables readback", rd_data[4:0], e);
      chk("R10 exported pins", {arb_en, host_mode, bridge_en}, {e[3], e[2], e[1]});
    end

    // R4 R8 R9: every event set under each pairing of int_en / orp_en
    for (int en = 0; en < 4; en++) begin
      for (int e = 0; e < 32; e++) begin
        logic [4:0] cw;
        logic       exp_irq;
        cw = {en[1], 3'b100, en[0]};
        wr(ctl(8'h30, cw) | CLR_ALL);
        @(negedge clk);
        pulse(e[4:0]);
        chk("R4 flags after pulse", rd_data, ctl(8'h30, cw) | ev_bits(e[4:0]));
        @(negedge clk);
        exp_irq = en[0] & ((e[1] & en[1]) | e[2] | e[3] | e[4]);
        chk(en[0] ? "R8 irq equation" : "R9 global gate", {63'h0, irq}, {63'h0, exp_irq});
      end
    end

    // R5: selective clear
    wr(ctl(8'h30, 5'h19) | CLR_ALL);
    pulse(5'h1F);
    wr(ctl(8'h30, 5'h19) | 64'h0400);
    chk("R5 clear only bit10", rd_data, ctl(8'h30, 5'h19) | ev_bits(5'h1B));
    wr(ctl(8'h30, 5'h19));
    chk("R5 zero write keeps flags", rd_data, ctl(8'h30, 5'h19) | ev_bits(5'h1B));

    // R6: event and clear in the same cycle
    @(negedge clk); ev = 5'h08; wr_en = 1'b1; wr_data = ctl(8'h30, 5'h19) | 64'h0200;
    @(negedge clk); ev = '0; wr_en = 1'b0; wr_data = '0;
    chk("R6 set wins over clear", rd_data[9], 64'h1);

    // R7: doorbell set, then set and clear together
    wr(ctl(8'h30, 5'h19) | CLR_ALL);
    wr(ctl(8'h30, 5'h19) | 64'h1000);
    chk("R7 bell status set, bit12 reads 0", rd_data, 64'h0030_0819);
    @(negedge clk);
    chk("R8 bell raises irq", {63'h0, irq}, 64'h1);
    wr(ctl(8'h30, 5'h19) | 64'h1800);
    chk("R6 bell set wins over clear", rd_data[11], 64'h1);
    wr(ctl(8'h30, 5'h19) | 64'h0800);
    chk("R5 bell clear", rd_data[11], 64'h0);
    @(negedge clk);
    chk("R8 irq drops", {63'h0, irq}, 64'h0);

    summary();
  end
endmodule